// File: doc/BRIEF.md
# Shared Memory Port Arbiter with Fetch Stall and Pipeline Freeze

This block sits between a five-stage in-order pipeline and a single memory port. Both the instruction fetch stage and the data access stage use this port. In every cycle it looks at the fetch request and at any load or store held in the data access stage. It hands the port to one of them, routes that requester's address, write enable and write data onto the port, and tells the fetch stage whether it has to hold.

The memory answers one cycle after a request, and it can take longer on a miss. The block keeps a registered owner tag for the access in flight and uses it to send the returned word to the right place. A returned instruction goes into the IF/ID register. A returned data word goes back to the data stage. While a response is late, the block raises a global freeze and starts no new access, so memory references complete in program order. In any cycle that delivers no instruction, it loads a NOP with a cleared valid bit into IF/ID. That bubble is how a stall shows up further down the pipe.

Top module: `shm_port_arbiter`

## Requirements
- R1: When the block is not frozen and `mem_req` is high, the port goes to the data stage in that cycle: `port_req`=1, `port_we`=`mem_we`, `port_addr`=`mem_addr`, `port_wdata`=`mem_wdata`.
- R2: When the block is not frozen, `mem_req` is low and `if_req` is high, the port goes to fetch: `port_req`=1, `port_we`=0, `port_addr`=`if_addr`. With no request and no freeze, `port_req`=0.
- R3: `fetch_stall` is high exactly when `if_req` is high and fetch is not granted the port in that cycle. The fetch stage keeps its address and retries.
- R4: An access is in flight from the cycle after its grant until the cycle in which `port_rvalid` is high. In any cycle where an access is in flight and `port_rvalid` is low, `freeze`=1 and `port_req`=0.
- R5: In the cycle an access completes (`port_rvalid`=1), the response is steered by the owner tag. For a data owner, `dm_rvalid`=1 and `dm_rdata`=`port_rdata`. For a fetch owner, `dm_rvalid`=0, and at the next clock edge `ifid_valid` becomes 1 with `ifid_instr` equal to that `port_rdata`.
- R6: In a cycle that is not frozen and delivers no fetch response, `bubble`=1. At the next edge IF/ID takes the NOP word (parameter `NOP_WORD`, default 32'h0000_0013) with `ifid_valid`=0.
- R7: During a frozen cycle, IF/ID keeps its contents across the clock edge.
- R8: After reset no access is in flight: `freeze`=0, `ifid_valid`=0, `ifid_instr`=`NOP_WORD`, and with no requests `fetch_stall`=0 and `port_req`=0.
- R9: Loads and stores in consecutive cycles win the port every time. Fetch stays stalled for the whole run, with no fairness limit.
- R10: A `port_rvalid` that arrives with no access in flight is ignored: `dm_rvalid`=0, and IF/ID receives a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_req | input | 1 | Fetch stage wants the port |
| if_addr | input | AW | Fetch address (PC) |
| fetch_stall | output | 1 | Fetch not granted; hold PC |
| mem_req | input | 1 | Load or store present in data stage |
| mem_we | input | 1 | 1 = store, 0 = load |
| mem_addr | input | AW | Data address |
| mem_wdata | input | DW | Store data |
| dm_rvalid | output | 1 | Data response for the data stage |
| dm_rdata | output | DW | Data response word |
| port_req | output | 1 | Request on the shared memory port |
| port_we | output | 1 | Write enable on the port |
| port_addr | output | AW | Address on the port |
| port_wdata | output | DW | Write data on the port |
| port_rvalid | input | 1 | Memory response valid |
| port_rdata | input | DW | Memory response word |
| freeze | output | 1 | Global pipeline freeze, access outstanding |
| bubble | output | 1 | IF/ID loads a NOP this cycle |
| ifid_valid | output | 1 | IF/ID valid bit |
| ifid_instr | output | DW | IF/ID instruction word |

## Verification
Two events can land in the same cycle. One is the completion of an earlier access, whose response has to be steered by the old owner tag. The other is the grant of a new access, which overwrites that tag. The bench provokes every such overlap by sweeping all ordered pairs of cycle stimuli built from fetch request, data request, write enable and response valid. Each pair therefore includes responses that arrive on time, late, or unsolicited, against every kind of new request. A separate arithmetic model computes owner, freeze, stall, bubble and IF/ID contents, and the bench judges the design cycle by cycle against it.

// File: rtl/shm_arb_pkg.sv
package shm_arb_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_FETCH = 2'd1,
    OWN_DATA  = 2'd2
  } owner_e;

  // Who gets the port this cycle: data stage has absolute priority.
  function automatic owner_e pick_owner(input logic frozen,
                                        input logic dreq,
                                        input logic freq);
    owner_e w;
    if (frozen)    w = OWN_NONE;
    else if (dreq) w = OWN_DATA;
    else if (freq) w = OWN_FETCH;
    else           w = OWN_NONE;
    return w;
  endfunction

  // An access is late when one is outstanding and no response came back.
  function automatic logic is_late(input owner_e inflight,
                                   input logic   rsp);
    return (inflight != OWN_NONE) && !rsp;
  endfunction

  // An access completes when one is outstanding and the response arrives.
  function automatic logic is_done(input owner_e inflight,
                                   input logic   rsp,
                                   input owner_e who);
    return (inflight == who) && rsp;
  endfunction

endpackage

// File: rtl/shm_owner_track.sv
module shm_owner_track
  import shm_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  owner_e grant,
  input  logic   rsp_valid,
  output owner_e inflight,
  output logic   frozen,
  output logic   done_fetch,
  output logic   done_data
);

  owner_e tag_q;

  assign inflight   = tag_q;
  assign frozen     = is_late(tag_q, rsp_valid);
  assign done_fetch = is_done(tag_q, rsp_valid, OWN_FETCH);
  assign done_data  = is_done(tag_q, rsp_valid, OWN_DATA);

  // The tag is kept while frozen; otherwise it follows the new grant.
  always_ff @(posedge clk) begin
    if (!rst_n)       tag_q <= OWN_NONE;
    else if (!frozen) tag_q <= grant;
  end

endmodule

// File: rtl/shm_port_mux.sv
module shm_port_mux
  import shm_arb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          rst_n,
  input  logic          frozen,
  input  logic          if_req,
  input  logic [AW-1:0] if_addr,
  input  logic          mem_req,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_wdata,
  output owner_e        grant,
  output logic          port_req,
  output logic          port_we,
  output logic [AW-1:0] port_addr,
  output logic [DW-1:0] port_wdata,
  output logic          fetch_stall
);

  logic block_all;

  assign block_all = frozen || !rst_n;
  assign grant     = pick_owner(block_all, mem_req, if_req);

  always_comb begin
    port_req   = 1'b0;
    port_we    = 1'b0;
    port_addr  = '0;
    port_wdata = '0;
    unique case (grant)
      OWN_DATA: begin
        port_req   = 1'b1;
        port_we    = mem_we;
        port_addr  = mem_addr;
        port_wdata = mem_wdata;
      end
      OWN_FETCH: begin
        port_req  = 1'b1;
        port_addr = if_addr;
      end
      default: ;
    endcase
  end

  assign fetch_stall = if_req && rst_n && (grant != OWN_FETCH);

endmodule

// File: rtl/shm_ifid_reg.sv
module shm_ifid_reg #(
  parameter int          DW       = 32,
  parameter logic [31:0] NOP_WORD = 32'h0000_0013
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frozen,
  input  logic          fetch_done,
  input  logic [DW-1:0] fetch_word,
  output logic          bubble,
  output logic          valid_q,
  output logic [DW-1:0] instr_q
);

  localparam logic [DW-1:0] NOP_W = DW'(NOP_WORD);

  assign bubble = !frozen && !fetch_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      instr_q <= NOP_W;
    end else if (fetch_done) begin
      valid_q <= 1'b1;
      instr_q <= fetch_word;
    end else if (bubble) begin
      valid_q <= 1'b0;
      instr_q <= NOP_W;
    end
  end

endmodule

// File: rtl/shm_port_arbiter.sv
module shm_port_arbiter
  import shm_arb_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 32,
  parameter logic [31:0] NOP_WORD = 32'h0000_0013
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          if_req,
  input  logic [AW-1:0] if_addr,
  output logic          fetch_stall,
  input  logic          mem_req,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_wdata,
  output logic          dm_rvalid,
  output logic [DW-1:0] dm_rdata,
  output logic          port_req,
  output logic          port_we,
  output logic [AW-1:0] port_addr,
  output logic [DW-1:0] port_wdata,
  input  logic          port_rvalid,
  input  logic [DW-1:0] port_rdata,
  output logic          freeze,
  output logic          bubble,
  output logic          ifid_valid,
  output logic [DW-1:0] ifid_instr
);

  owner_e grant;
  owner_e inflight;
  logic   frozen;
  logic   fetch_rsp;
  logic   data_rsp;

  shm_owner_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant      (grant),
    .rsp_valid  (port_rvalid),
    .inflight   (inflight),
    .frozen     (frozen),
    .done_fetch (fetch_rsp),
    .done_data  (data_rsp)
  );

  shm_port_mux #(.AW(AW), .DW(DW)) u_mux (
    .rst_n       (rst_n),
    .frozen      (frozen),
    .if_req      (if_req),
    .if_addr     (if_addr),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .grant       (grant),
    .port_req    (port_req),
    .port_we     (port_we),
    .port_addr   (port_addr),
    .port_wdata  (port_wdata),
    .fetch_stall (fetch_stall)
  );

  shm_ifid_reg #(.DW(DW), .NOP_WORD(NOP_WORD)) u_ifid (
    .clk        (clk),
    .rst_n      (rst_n),
    .frozen     (frozen),
    .fetch_done (fetch_rsp),
    .fetch_word (port_rdata),
    .bubble     (bubble),
    .valid_q    (ifid_valid),
    .instr_q    (ifid_instr)
  );

  assign freeze    = frozen;
  assign dm_rvalid = data_rsp;
  assign dm_rdata  = data_rsp ? port_rdata : '0;

endmodule

// File: rtl/shm_port_arbiter_chk.sv
module shm_port_arbiter_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          if_req,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          port_req,
  input logic          port_we,
  input logic [AW-1:0] port_addr,
  input logic          port_rvalid,
  input logic          freeze,
  input logic          fetch_stall,
  input logic          fetch_rsp,
  input logic          dm_rvalid,
  input logic          ifid_valid,
  input logic [DW-1:0] ifid_instr
);

  a_r1_data_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !freeze) |-> (port_req && port_we == mem_we && port_addr == mem_addr));

  a_r3_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && if_req) |-> fetch_stall);

  a_r4_quiet_when_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !port_req);

  a_r4_late_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(port_req) && !port_rvalid) |-> freeze);

  a_r5_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_rsp, dm_rvalid}));

  a_r7_hold_ifid: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(ifid_valid) && $stable(ifid_instr)));

endmodule

bind shm_port_arbiter shm_port_arbiter_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .if_req      (if_req),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .port_req    (port_req),
  .port_we     (port_we),
  .port_addr   (port_addr),
  .port_rvalid (port_rvalid),
  .freeze      (freeze),
  .fetch_stall (fetch_stall),
  .fetch_rsp   (fetch_rsp),
  .dm_rvalid   (dm_rvalid),
  .ifid_valid  (ifid_valid),
  .ifid_instr  (ifid_instr)
);

// File: tb/shm_port_arbiter_test.sv
module shm_port_arbiter_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [31:0] NOP = 32'h0000_0013;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          if_req, mem_req, mem_we, port_rvalid;
  logic [AW-1:0] if_addr, mem_addr;
  logic [DW-1:0] mem_wdata, port_rdata;
  logic          fetch_stall, dm_rvalid, port_req, port_we, freeze, bubble, ifid_valid;
  logic [DW-1:0] dm_rdata, port_wdata, ifid_instr;
  logic [AW-1:0] port_addr;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // bench reference state: 0 none, 1 fetch, 2 data
  int          m_tag = 0;
  logic        m_v   = 1'b0;
  logic [31:0] m_i   = NOP;

  always #(CLK_PERIOD/2) clk = ~clk;

  shm_port_arbiter uut (
    .clk(clk), .rst_n(rst_n), .if_req(if_req), .if_addr(if_addr),
    .fetch_stall(fetch_stall), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .dm_rvalid(dm_rvalid),
    .dm_rdata(dm_rdata), .port_req(port_req), .port_we(port_we),
    .port_addr(port_addr), .port_wdata(port_wdata), .port_rvalid(port_rvalid),
    .port_rdata(port_rdata), .freeze(freeze), .bubble(bubble),
    .ifid_valid(ifid_valid), .ifid_instr(ifid_instr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, compare at negedge+1, update model.
  task automatic step(input logic ir, input logic mr, input logic we, input logic rv, input int seed);
    logic frz, dn_f, dn_d, g_d, g_f;
    @(negedge clk);
    if_req      = ir;
    mem_req     = mr;
    mem_we      = we;
    port_rvalid = rv;
    if_addr     = AW'(seed * 4 + 16'h100);
    mem_addr    = AW'(seed * 8 + 16'h8000);
    mem_wdata   = 32'hA500_0000 + 32'(seed);
    port_rdata  = 32'h5A00_0000 + 32'(seed * 3);
    #1;
    frz  = (m_tag != 0) && !rv;
    dn_f = (m_tag == 1) && rv;
    dn_d = (m_tag == 2) && rv;
    g_d  = !frz && mr;
    g_f  = !frz && !mr && ir;
    chk("R4 freeze", 64'(freeze), 64'(frz));
    chk("R1/R2/R4 port_req", 64'(port_req), 64'(g_d || g_f));
    if (g_d) begin
      chk("R1 port_we",    64'(port_we),    64'(we));
      chk("R1 port_addr",  64'(port_addr),  64'(mem_addr));
      chk("R1 port_wdata", 64'(port_wdata), 64'(mem_wdata));
    end
    if (g_f) begin
      chk("R2 port_we",   64'(port_we),   64'd0);
      chk("R2 port_addr", 64'(port_addr), 64'(if_addr));
    end
    chk("R3/R9 fetch_stall", 64'(fetch_stall), 64'(ir && !g_f));
    chk("R5/R10 dm_rvalid", 64'(dm_rvalid), 64'(dn_d));
    if (dn_d) chk("R5 dm_rdata", 64'(dm_rdata), 64'(port_rdata));
    chk("R6 bubble", 64'(bubble), 64'(!frz && !dn_f));
    chk("R5/R6/R7 ifid_valid", 64'(ifid_valid), 64'(m_v));
    chk("R5/R6/R7 ifid_instr", 64'(ifid_instr), 64'(m_i));
    if (!frz) begin
      m_tag = g_d ? 2 : (g_f ? 1 : 0);
      if (dn_f) begin m_v = 1'b1; m_i = port_rdata; end
      else      begin m_v = 1'b0; m_i = NOP;        end
    end
  endtask

  initial begin
    rst_n = 1'b0; if_req = 0; mem_req = 0; mem_we = 0; port_rvalid = 0;
    if_addr = '0; mem_addr = '0; mem_wdata = '0; port_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk("R8 freeze", 64'(freeze), 64'd0);
    chk("R8 fetch_stall", 64'(fetch_stall), 64'd0);
    chk("R8 port_req", 64'(port_req), 64'd0);
    chk("R8 ifid_valid", 64'(ifid_valid), 64'd0);
    chk("R8 ifid_instr", 64'(ifid_instr), 64'(NOP));
    rst_n = 1'b1;
    // R10: stray response straight after reset
    step(1'b0, 1'b0, 1'b0, 1'b1, 1);
    // Sweep of all ordered pairs of cycle stimuli {if_req,mem_req,mem_we,rvalid}
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        step(a[3], a[2], a[1], a[0], a * 16 + b);
        step(b[3], b[2], b[1], b[0], a * 16 + b + 1000);
      end
    end
    // R4: long miss on a load, then R9: back-to-back data accesses
    step(1'b0, 1'b0, 1'b0, 1'b1, 2000);
    step(1'b1, 1'b1, 1'b0, 1'b0, 2001);
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b1, 1'b0, 2002 + k);
    for (int k = 0; k < 10; k++) step(1'b1, 1'b1, k[0], 1'b1, 2100 + k);
    // fetch resumes and a fetch response lands in IF/ID (R5)
    step(1'b1, 1'b0, 1'b0, 1'b1, 2200);
    step(1'b1, 1'b0, 1'b0, 1'b1, 2201);
    step(1'b0, 1'b0, 1'b0, 1'b1, 2202);
    step(1'b0, 1'b0, 1'b0, 1'b0, 2203);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule